// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges the reset causes of a processor supervisor into one stretched reset. It takes three causes. The first is a supply-good flag from an external voltage comparator. The second is a single-cycle timeout pulse from a watchdog. The third is an already-debounced pushbutton request.

A level cause (supply low or button held) keeps reset asserted for as long as it is present. Once it clears, a fixed stretch of reset follows. A pulse cause starts one full stretch. The stretch is counted in periods of an external millisecond tick. Its default of 610 ticks sits inside an allowed window of 250 to 1000 ms.

Reset leaves the block on three outputs that always agree:
- an active-high reset;
- an enable for an open-drain pull-down that forms the active-low reset;
- a status copy.

Top module: `supv_reset_gen`

## Requirements
- R1: While `srst` is high, `rst` is 1. After `srst` falls with no cause present, `rst` stays 1 until `STRETCH_TICKS` ticks have been sampled, then reads 0.
- R2: If `supply_ok` is 0 at a clock edge, `rst` is 1 after that same edge. This is one clock of detection delay, far below the 150 µs bound.
- R3: `rst` stays 1 on every cycle that `supply_ok` is 0, whatever the tick does.
- R4: After `supply_ok` returns to 1, `rst` stays 1 for exactly `STRETCH_TICKS` sampled ticks. It reads 0 after the edge that samples the last of them.
- R5: A one-cycle `wdt_timeout` pulse sets `rst` to 1 after that edge. `rst` then stays 1 for `STRETCH_TICKS` sampled ticks.
- R6: `rst` is 1 while `pb_active` is 1. After `pb_active` returns to 0, `rst` stays 1 for `STRETCH_TICKS` sampled ticks.
- R7: Any cause that arrives during a stretch, including one sampled together with a tick, reloads the full interval. The interval is never shortened.
- R8: `rst`, `rst_n_pull_low` and `reset_active` hold the same value on every cycle. A value of 1 on `rst_n_pull_low` means the low-side pull is on.
- R9: `rst` can fall only after an edge at which `ms_tick` was 1. If no tick is sampled, `rst` stays at 1.
- R10: With no cause present and no stretch running, ticks leave `rst` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset; acts like a supply that has just come good |
| ms_tick | input | 1 | One-cycle pulse per stretch time unit |
| supply_ok | input | 1 | 1 when the supply is above the trip point |
| wdt_timeout | input | 1 | One-cycle watchdog expiry pulse |
| pb_active | input | 1 | 1 while the debounced pushbutton is pressed |
| rst | output | 1 | Active-high reset |
| rst_n_pull_low | output | 1 | 1 enables the open-drain pull-down of the active-low reset |
| reset_active | output | 1 | Status copy of the reset state |

## Verification
The bench builds the block with `STRETCH_TICKS` set to 3 and drives `ms_tick` itself cycle by cycle. This brings the full end of every stretch within a few cycles. It also allows the bench to place tick-free cycles inside a stretch and to retrigger a stretch when one tick remains. With the short count, the bench can end each scenario exactly on the edge where reset should drop. It can also drive a cause and a tick in the same cycle.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Causes that can hold or start a reset
    typedef struct packed {
        logic supply_low;   // level cause
        logic button;       // level cause
        logic wdog;         // pulse cause
    } cause_t;

    function automatic logic any_cause(input cause_t c);
        return c.supply_low | c.button | c.wdog;
    endfunction

    function automatic int cnt_width(input int ticks);
        return (ticks < 1) ? 1 : $clog2(ticks + 1);
    endfunction

endpackage

// File: rtl/supv_cause_merge.sv
module supv_cause_merge
    import supv_pkg::*;
(
    input  logic   supply_ok,
    input  logic   wdt_timeout,
    input  logic   pb_active,
    output cause_t causes,
    output logic   cause_any
);
    always_comb begin
        causes.supply_low = ~supply_ok;
        causes.button     = pb_active;
        causes.wdog       = wdt_timeout;
        cause_any         = any_cause(causes);
    end
endmodule

// File: rtl/supv_stretch_counter.sv
module supv_stretch_counter
    import supv_pkg::*;
#(
    parameter int STRETCH_TICKS = 610
) (
    input  logic clk,
    input  logic srst,
    input  logic tick,
    input  logic load,
    output logic hold_req
);
    localparam int CNT_W = cnt_width(STRETCH_TICKS);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt_q;
        if (load)
            cnt_nxt = RELOAD;
        else if (tick && cnt_q != '0)
            cnt_nxt = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (srst)
            cnt_q <= RELOAD;
        else
            cnt_q <= cnt_nxt;
    end

    // Reset is requested while the updated count is non-zero
    assign hold_req = (cnt_nxt != '0) | srst;

    // R7
    reload_full_chk: assert property (@(posedge clk) disable iff (srst)
        load |=> cnt_q == RELOAD);

    // R9
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (srst)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/supv_reset_drive.sv
module supv_reset_drive (
    input  logic clk,
    input  logic srst,
    input  logic req,
    output logic rst_hi,
    output logic pull_lo_en,
    output logic status
);
    logic hi_q;
    logic lo_q;

    // Separate flops per output, as at two pads
    always_ff @(posedge clk) begin
        if (srst) begin
            hi_q <= 1'b1;
            lo_q <= 1'b1;
        end else begin
            hi_q <= req;
            lo_q <= req;
        end
    end

    assign rst_hi     = hi_q;
    assign pull_lo_en = lo_q;
    assign status     = hi_q;

    // R8
    polarity_pair_chk: assert property (@(posedge clk) disable iff (srst)
        hi_q == lo_q);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int STRETCH_TICKS = 610
) (
    input  logic clk,
    input  logic srst,
    input  logic ms_tick,
    input  logic supply_ok,
    input  logic wdt_timeout,
    input  logic pb_active,
    output logic rst,
    output logic rst_n_pull_low,
    output logic reset_active
);
    cause_t causes;
    logic   cause_any;
    logic   hold_req;

    supv_cause_merge u_merge (
        .supply_ok   (supply_ok),
        .wdt_timeout (wdt_timeout),
        .pb_active   (pb_active),
        .causes      (causes),
        .cause_any   (cause_any)
    );

    supv_stretch_counter #(
        .STRETCH_TICKS (STRETCH_TICKS)
    ) u_stretch (
        .clk      (clk),
        .srst     (srst),
        .tick     (ms_tick),
        .load     (cause_any),
        .hold_req (hold_req)
    );

    supv_reset_drive u_drive (
        .clk        (clk),
        .srst       (srst),
        .req        (hold_req),
        .rst_hi     (rst),
        .pull_lo_en (rst_n_pull_low),
        .status     (reset_active)
    );

    // R2
    supply_detect_chk: assert property (@(posedge clk) disable iff (srst)
        causes.supply_low |=> rst);

    // R5
    wdog_assert_chk: assert property (@(posedge clk) disable iff (srst)
        wdt_timeout |=> rst);

    // R6
    button_hold_chk: assert property (@(posedge clk) disable iff (srst)
        pb_active |=> rst);

    // R9
    no_early_release_chk: assert property (@(posedge clk) disable iff (srst)
        (rst && !ms_tick) |=> rst);
endmodule

// File: tb/tb_supv_reset_gen.sv
module tb_supv_reset_gen;
    localparam int N = 3;

    logic clk = 1'b0;
    logic srst, ms_tick, supply_ok, wdt_timeout, pb_active;
    logic rst, rst_n_pull_low, reset_active;

    int checks = 0;
    int fails  = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    supv_reset_gen #(.STRETCH_TICKS(N)) dut (
        .clk            (clk),
        .srst           (srst),
        .ms_tick        (ms_tick),
        .supply_ok      (supply_ok),
        .wdt_timeout    (wdt_timeout),
        .pb_active      (pb_active),
        .rst            (rst),
        .rst_n_pull_low (rst_n_pull_low),
        .reset_active   (reset_active)
    );

    // Driver: inputs for one edge plus the rst expected after it
    task automatic step(input logic r, input logic sup, input logic wd,
                        input logic pb, input logic tk, input logic exp,
                        input string tag);
        @(negedge clk);
        srst = r; supply_ok = sup; wdt_timeout = wd; pb_active = pb; ms_tick = tk;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares after each edge, away from it
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rst !== e) begin
                fails++;
                $display("FAIL %s: rst=%b expected %b", t, rst, e);
            end
            checks++;
            if (rst_n_pull_low !== rst || reset_active !== rst) begin
                fails++;
                $display("FAIL R8: pull_low=%b status=%b expected %b",
                         rst_n_pull_low, reset_active, rst);
            end
        end
    end

    task automatic scenario;
        // R1: held in reset, then a full stretch
        step(1, 1, 0, 0, 0, 1, "R1");
        step(1, 1, 0, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 0, 1, "R1");
        step(0, 1, 0, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 0, 1, "R9");
        step(0, 1, 0, 0, 1, 0, "R1");
        // R10: idle ticks change nothing
        step(0, 1, 0, 0, 1, 0, "R10");
        step(0, 1, 0, 0, 1, 0, "R10");
        // R2/R3: supply low
        step(0, 0, 0, 0, 0, 1, "R2");
        step(0, 0, 0, 0, 1, 1, "R3");
        step(0, 0, 0, 0, 1, 1, "R3");
        step(0, 0, 0, 0, 1, 1, "R3");
        step(0, 0, 0, 0, 1, 1, "R3");
        // R4: recovery stretch
        step(0, 1, 0, 0, 1, 1, "R4");
        step(0, 1, 0, 0, 0, 1, "R9");
        step(0, 1, 0, 0, 1, 1, "R4");
        step(0, 1, 0, 0, 1, 0, "R4");
        step(0, 1, 0, 0, 0, 0, "R10");
        // R5: watchdog pulse
        step(0, 1, 1, 0, 0, 1, "R5");
        step(0, 1, 0, 0, 1, 1, "R5");
        step(0, 1, 0, 0, 1, 1, "R5");
        step(0, 1, 0, 0, 1, 0, "R5");
        // R6: button held then released
        step(0, 1, 0, 1, 1, 1, "R6");
        step(0, 1, 0, 1, 1, 1, "R6");
        step(0, 1, 0, 1, 1, 1, "R6");
        step(0, 1, 0, 1, 1, 1, "R6");
        step(0, 1, 0, 0, 1, 1, "R6");
        step(0, 1, 0, 0, 1, 1, "R6");
        step(0, 1, 0, 0, 1, 0, "R6");
        // R7: retrigger with one tick left, cause together with tick
        step(0, 1, 1, 0, 0, 1, "R7");
        step(0, 1, 0, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 1, 1, "R7");
        step(0, 1, 1, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 0, 1, "R9");
        step(0, 1, 0, 0, 1, 1, "R7");
        step(0, 1, 0, 0, 1, 0, "R7");
        // R1: srst mid-stretch reloads
        step(0, 1, 1, 0, 0, 1, "R5");
        step(0, 1, 0, 0, 1, 1, "R5");
        step(1, 1, 0, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 1, 1, "R1");
        step(0, 1, 0, 0, 1, 0, "R1");
        step(0, 1, 0, 0, 1, 0, "R10");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        srst = 1; supply_ok = 1; wdt_timeout = 0; pb_active = 0; ms_tick = 0;
        fork
            scenario();
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule